// File: doc/BRIEF.md
# Transport Stream Packet Identifier Filter

This block sits on a byte-wide transport stream input and decides, packet by packet, whether each 188-byte packet goes on or is thrown away. Every packet starts with a sync byte of 0x47. Its 13-bit packet identifier is carried in bits 4:0 of header byte 1, followed by all of header byte 2. The identifier is compared against eight programmable match slots. Packets that pass are repacked into 32-bit words and sent out in full, 47 words per packet, behind a valid/ready handshake. The words carry start and end markers.

Software programs the slots through a small 32-bit register port. Each slot holds an identifier and an enable bit. Slot 0's word also holds three global controls: a pass-everything override, a filter-off flag that blocks all output, and the byte order of the output words. The decision and the byte order are taken when header byte 2 arrives, so at most three bytes wait before the first output word forms.

The parser is a four-state machine. IDLE waits for a start-strobed sync byte. HDR collects header bytes 1 and 2. FWD passes the rest of the packet, and SKIP discards it. The transitions are: IDLE to HDR on a strobed 0x47. HDR to FWD or HDR to SKIP on byte 2, depending on the decision. FWD to IDLE and SKIP to IDLE on byte 187.

Top module: `tspid_filter`

## Requirements
- R1: There are eight slot registers. Slot n is addressed by byte address n*4; an address with bits 1:0 not zero neither writes nor reads. Writes keep bits 15 and 12:0 in every slot, plus bits 16, 14 and 13 in slot 0 only; all other bits read back 0. After reset, slot 0 reads 0x00003FFF and slots 1 to 7 read 0x00001FFF.
- R2: A slot matches a packet when its bit 15 (enable) is 1 and its bits 12:0 equal the packet identifier. A slot with bit 15 clear never matches, even if its identifier is equal.
- R3: When bit 16 of slot 0 is 1, every packet with a valid sync byte passes, whatever the slots hold.
- R4: When bit 13 of slot 0 is 1, no packet produces output, even if bit 16 is set. This bit is 1 after reset.
- R5: Bit 14 of slot 0 selects the output byte order. When it is 0, the earliest of four bytes goes in bits 31:24. When it is 1, the earliest byte goes in bits 7:0.
- R6: The packet identifier is {byte1[4:0], byte2}. Bits 7:5 of byte 1 have no effect on the decision.
- R7: A start-strobed first byte other than 0x47 makes the whole packet drop. The parser then ignores bytes until the next start strobe. Bytes that arrive without a start strobe while the parser is idle are ignored.
- R8: A passing packet yields exactly 47 words in stream order. The start marker is set on the first word only and the end marker on the last word only. A dropped packet yields no word.
- R9: The pass decision and byte order are sampled on header byte 2. Register writes after that point do not affect the packet in flight.
- R10: in_ready is low only while an output word is held and out_ready is low. While out_ready is low, a held word and its markers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_sop | output | 1 | Word is the first of a packet |
| out_eop | output | 1 | Word is the last of a packet |
| out_data | output | 32 | Output word |

## Verification
A table of packets is sent against a fixed slot setup. It includes exact hits on different slots, an equal identifier in a disabled slot, the parked identifier 0x1FFF, a near miss one count away, and hits whose byte 1 carries set upper bits. Together these separate enable gating, field extraction and comparison width. Directed packets then set the pass-all bit and the filter-off bit, alone and together, to show which one dominates, and repeat a hit in both byte orders. Bad sync, stray unstrobed bytes, a register write in the middle of a packet, and random and full back-pressure each show a different way the packet boundary or the sampled decision could be disturbed.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int PID_W   = 13;
    localparam int OFF_BIT = 13;
    localparam int LE_BIT  = 14;
    localparam int EN_BIT  = 15;
    localparam int ALL_BIT = 16;

    localparam logic [7:0]  SYNC_BYTE = 8'h47;
    localparam logic [31:0] PARK_PID  = 32'h0000_1FFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_FWD,
        ST_SKIP
    } tsf_state_e;

    function automatic logic [31:0] slot_mask(input int idx);
        logic [31:0] m;
        m = (32'd1 << EN_BIT) | ((32'd1 << PID_W) - 32'd1);
        if (idx == 0)
            m = m | (32'd1 << OFF_BIT) | (32'd1 << LE_BIT) | (32'd1 << ALL_BIT);
        return m;
    endfunction

    function automatic logic [31:0] slot_reset(input int idx);
        return (idx == 0) ? (PARK_PID | (32'd1 << OFF_BIT)) : PARK_PID;
    endfunction

endpackage

// File: rtl/tsf_regs.sv
module tsf_regs
    import tsf_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3,
    parameter int AW     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [AW-1:0]                     cfg_addr,
    input  logic [31:0]                       cfg_wdata,
    output logic [31:0]                       cfg_rdata,
    output logic [NSLOT-1:0]                  slot_en,
    output logic [NSLOT-1:0][PID_W-1:0]       slot_pid,
    output logic                              ctl_all,
    output logic                              ctl_off,
    output logic                              ctl_le
);

    logic [NSLOT-1:0][31:0] slot_q;
    logic [SLOT_W-1:0]      sel;
    logic                   aligned;

    assign sel     = cfg_addr[AW-1:2];
    assign aligned = (cfg_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++)
                slot_q[i] <= slot_reset(i);
        end else if (cfg_we && aligned) begin
            for (int i = 0; i < NSLOT; i++)
                if (sel == SLOT_W'(i))
                    slot_q[i] <= cfg_wdata & slot_mask(i);
        end
    end

    assign cfg_rdata = aligned ? slot_q[sel] : 32'd0;

    assign ctl_all = slot_q[0][ALL_BIT];
    assign ctl_off = slot_q[0][OFF_BIT];
    assign ctl_le  = slot_q[0][LE_BIT];

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            assign slot_en[g]  = slot_q[g][EN_BIT];
            assign slot_pid[g] = slot_q[g][PID_W-1:0];

            AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_addr == AW'(g * 4)) |=>
                    (slot_q[g] == ($past(cfg_wdata) & slot_mask(g)))) // R1
                else $error("slot write mismatch");
        end
    endgenerate

endmodule

// File: rtl/tsf_match.sv
module tsf_match
    import tsf_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [NSLOT-1:0]            slot_en,
    input  logic [NSLOT-1:0][PID_W-1:0] slot_pid,
    input  logic [PID_W-1:0]            pkt_pid,
    output logic                        hit
);

    logic [NSLOT-1:0] hit_v;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
            assign hit_v[g] = slot_en[g] && (slot_pid[g] == pkt_pid);
        end
    endgenerate

    assign hit = |hit_v;

endmodule

// File: rtl/tsf_outreg.sv
module tsf_outreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         ld_sop,
    input  logic         ld_eop,
    output logic         room,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_sop,
    output logic         out_eop
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_sop   <= ld_sop;
            out_eop   <= ld_eop;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign room = !out_valid || out_ready;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))) // R10
        else $error("held word changed");

    AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop)) // R8
        else $error("start and end marker together");

endmodule

// File: rtl/tspid_filter.sv
module tspid_filter
    import tsf_pkg::*;
#(
    parameter int NSLOT     = 8,
    parameter int PKT_BYTES = 188
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_sop,
    output logic        out_eop,
    output logic [31:0] out_data
);

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int AW     = SLOT_W + 2;
    localparam int CNT_W  = $clog2(PKT_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_BYTES - 1);
    localparam logic [CNT_W-1:0] DEC_IDX  = CNT_W'(2);
    localparam logic [CNT_W-1:0] FIRST_W  = CNT_W'(3);

    logic [NSLOT-1:0]            slot_en;
    logic [NSLOT-1:0][PID_W-1:0] slot_pid;
    logic                        ctl_all, ctl_off, ctl_le;
    logic                        hit;
    logic [PID_W-1:0]            pkt_pid;

    tsf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [23:0]      acc_q;
    logic             le_q;
    logic             accept, pass_now, decide;
    logic             word_fire, word_sop, word_eop;
    logic [31:0]      word_data;
    logic             room;

    tsf_regs #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr[AW-1:0]),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .slot_en   (slot_en),
        .slot_pid  (slot_pid),
        .ctl_all   (ctl_all),
        .ctl_off   (ctl_off),
        .ctl_le    (ctl_le)
    );

    assign pkt_pid = {acc_q[4:0], in_data};

    tsf_match #(.NSLOT(NSLOT)) u_match (
        .slot_en  (slot_en),
        .slot_pid (slot_pid),
        .pkt_pid  (pkt_pid),
        .hit      (hit)
    );

    assign in_ready = room;
    assign accept   = in_valid && in_ready;
    assign pass_now = !ctl_off && (ctl_all || hit);
    assign decide   = accept && (state_q == ST_HDR) && (cnt_q == DEC_IDX);

    // next state and byte position
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && in_sop && in_data == SYNC_BYTE) begin
                    state_d = ST_HDR;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_HDR: begin
                if (accept) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == DEC_IDX)
                        state_d = pass_now ? ST_FWD : ST_SKIP;
                end
            end
            ST_FWD, ST_SKIP: begin
                if (accept) begin
                    if (cnt_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
            le_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept)
                acc_q <= {acc_q[15:0], in_data};
            if (decide)
                le_q <= ctl_le;
        end
    end

    // word assembly outputs
    always_comb begin
        word_fire = 1'b0;
        word_sop  = 1'b0;
        word_eop  = 1'b0;
        word_data = le_q ? {in_data, acc_q[7:0], acc_q[15:8], acc_q[23:16]}
                         : {acc_q, in_data};
        unique case (state_q)
            ST_FWD: begin
                word_fire = accept && (cnt_q[1:0] == 2'b11);
                word_sop  = (cnt_q == FIRST_W);
                word_eop  = (cnt_q == LAST_IDX);
            end
            ST_IDLE, ST_HDR, ST_SKIP: begin
                word_fire = 1'b0;
            end
        endcase
    end

    tsf_outreg #(.W(32)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (word_fire),
        .ld_data   (word_data),
        .ld_sop    (word_sop),
        .ld_eop    (word_eop),
        .room      (room),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX) // R8
        else $error("byte position out of range");

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && ctl_off) |=> (state_q == ST_SKIP)) // R4
        else $error("packet forwarded while filter off");

endmodule

// File: tb/sim_tspid_filter.sv
`timescale 1ns/1ps
module sim_tspid_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        in_valid, in_sop, in_ready;
    logic [7:0]  in_data;
    logic        out_valid, out_sop, out_eop;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    tspid_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;
    int rdy_mode = 0;
    bit tx_busy = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    end

    logic [31:0] rx_word [64];
    bit          rx_sop  [64];
    bit          rx_eop  [64];
    int          rx_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (rx_cnt < 64) begin
                rx_word[rx_cnt] = out_data;
                rx_sop[rx_cnt]  = out_sop;
                rx_eop[rx_cnt]  = out_eop;
            end
            rx_cnt = rx_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int i, input logic [12:0] pid,
                                         input logic [2:0] hi, input logic [7:0] seed);
        if (i == 0) return 8'h47;
        if (i == 1) return {hi, pid[12:8]};
        if (i == 2) return pid[7:0];
        return 8'(i * 7) + seed;
    endfunction

    function automatic logic [31:0] eword(input int k, input logic [12:0] pid,
                                          input logic [2:0] hi, input logic [7:0] seed, input bit le);
        logic [7:0] b0, b1, b2, b3;
        b0 = pbyte(4*k, pid, hi, seed);
        b1 = pbyte(4*k+1, pid, hi, seed);
        b2 = pbyte(4*k+2, pid, hi, seed);
        b3 = pbyte(4*k+3, pid, hi, seed);
        return le ? {b3, b2, b1, b0} : {b0, b1, b2, b3};
    endfunction

    task automatic send_pkt(input logic [7:0] first, input logic [12:0] pid, input logic [2:0] hi,
                            input logic [7:0] seed, input bit midwr, input logic [31:0] midval);
        tx_busy = 1;
        for (int i = 0; i < 188; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sop    = (i == 0);
            in_data   = (i == 0) ? first : pbyte(i, pid, hi, seed);
            cfg_we    = midwr && (i == 10);
            cfg_addr  = 5'd0;
            cfg_wdata = midval;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        cfg_we   = 1'b0;
        tx_busy  = 0;
    endtask

    task automatic stray_bytes();
        logic [7:0] vals [3] = '{8'h47, 8'h11, 8'h22};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = 1'b0;
            in_data  = vals[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int idle = 0;
        while (idle < 6) begin
            @(negedge clk);
            if (out_valid) idle = 0;
            else idle++;
        end
    endtask

    task automatic clear_rx();
        @(negedge clk);
        rx_cnt = 0;
    endtask

    task automatic wr(input int slot, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(slot * 4);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = addr;
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic verify(input logic [12:0] pid, input logic [2:0] hi, input logic [7:0] seed,
                          input bit le, input bit exp_pass, input string tag);
        int n;
        int bad;
        n = exp_pass ? 47 : 0;
        bad = 0;
        chk(rx_cnt == n, {tag, " word count"}, 32'(rx_cnt), 32'(n));
        if (exp_pass && rx_cnt == 47) begin
            for (int k = 0; k < 47; k++)
                if (rx_word[k] != eword(k, pid, hi, seed, le) ||
                    rx_sop[k] != (k == 0) || rx_eop[k] != (k == 46))
                    bad++;
            chk(bad == 0, {tag, " content and markers"}, 32'(bad), 32'd0);
        end
    endtask

    // {pid, byte1 upper bits, expected pass} against slots set up below
    localparam logic [16:0] VEC [8] = '{
        {13'h0100, 3'd0, 1'b1},
        {13'h1FFE, 3'd0, 1'b1},
        {13'h0200, 3'd0, 1'b0},
        {13'h0000, 3'd7, 1'b1},
        {13'h0101, 3'd0, 1'b0},
        {13'h1FFF, 3'd0, 1'b0},
        {13'h0100, 3'd5, 1'b1},
        {13'h0800, 3'd0, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk(out_valid == 1'b0, "R10 reset no output", 32'(out_valid), 32'd0);
        rd_chk(5'd0,  32'h0000_3FFF, "R1 R4 reset slot0");
        rd_chk(5'd20, 32'h0000_1FFF, "R1 reset slot5");
        rd_chk(5'd2,  32'h0000_0000, "R1 unaligned read");

        // filter off after reset: nothing forwarded
        clear_rx();
        send_pkt(8'h47, 13'h1FFF, 3'd0, 8'h10, 0, 0);
        drain();
        verify(13'h1FFF, 3'd0, 8'h10, 0, 0, "R4 reset blocks");

        // write masks
        wr(3, 32'hFFFF_FFFF);
        rd_chk(5'd12, 32'h0000_9FFF, "R1 slot3 mask");
        wr(0, 32'hFFFF_FFFF);
        rd_chk(5'd0, 32'h0001_FFFF, "R1 slot0 mask");
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'd5; cfg_wdata = 32'h0000_8123;
        @(negedge clk); cfg_we = 1'b0;
        rd_chk(5'd4, 32'h0000_1FFF, "R1 unaligned write ignored");

        // table setup
        wr(0, 32'h0000_8100);
        wr(1, 32'h0000_9FFE);
        wr(2, 32'h0000_0200);
        wr(3, 32'h0000_1FFF);
        wr(7, 32'h0000_8000);

        for (int v = 0; v < 8; v++) begin
            clear_rx();
            send_pkt(8'h47, VEC[v][16:4], VEC[v][3:1], 8'(v * 13), 0, 0);
            drain();
            verify(VEC[v][16:4], VEC[v][3:1], 8'(v * 13), 0, VEC[v][0], "R2 R6 R8 table");
        end

        // pass-all override
        wr(0, 32'h0001_8100);
        clear_rx();
        send_pkt(8'h47, 13'h0800, 3'd0, 8'h21, 0, 0);
        drain();
        verify(13'h0800, 3'd0, 8'h21, 0, 1, "R3 pass all");

        // filter off dominates pass-all
        wr(0, 32'h0001_A100);
        clear_rx();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h22, 0, 0);
        drain();
        verify(13'h0100, 3'd0, 8'h22, 0, 0, "R4 off over pass all");

        // little-endian output
        wr(0, 32'h0000_C100);
        clear_rx();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h33, 0, 0);
        drain();
        verify(13'h0100, 3'd0, 8'h33, 1, 1, "R5 little endian");
        chk(rx_word[0] == {pbyte(3, 13'h0100, 3'd0, 8'h33), 8'h00, 8'h01, 8'h47},
            "R5 first word", rx_word[0], {pbyte(3, 13'h0100, 3'd0, 8'h33), 8'h00, 8'h01, 8'h47});

        // bad sync and stray bytes
        wr(0, 32'h0000_8100);
        clear_rx();
        send_pkt(8'h46, 13'h0100, 3'd0, 8'h44, 0, 0);
        stray_bytes();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h55, 0, 0);
        drain();
        verify(13'h0100, 3'd0, 8'h55, 0, 1, "R7 resync");

        // write during packet does not touch it
        clear_rx();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h66, 1, 32'h0000_E100);
        drain();
        verify(13'h0100, 3'd0, 8'h66, 0, 1, "R9 in-flight kept");
        clear_rx();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h67, 0, 0);
        drain();
        verify(13'h0100, 3'd0, 8'h67, 0, 0, "R9 next packet off");
        wr(0, 32'h0000_8100);

        // random back-pressure
        rdy_mode = 1;
        clear_rx();
        send_pkt(8'h47, 13'h0100, 3'd0, 8'h77, 0, 0);
        rdy_mode = 0;
        drain();
        verify(13'h0100, 3'd0, 8'h77, 0, 1, "R10 random stall");

        // full stall
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        clear_rx();
        fork
            send_pkt(8'h47, 13'h0100, 3'd0, 8'h88, 0, 0);
        join_none
        repeat (20) @(negedge clk);
        d0 = out_data;
        chk(out_valid && !in_ready, "R10 stall blocks input", {30'd0, out_valid, in_ready}, 32'd2);
        repeat (5) @(negedge clk);
        chk(out_data == d0 && d0 == eword(0, 13'h0100, 3'd0, 8'h88, 0),
            "R10 held word stable", out_data, eword(0, 13'h0100, 3'd0, 8'h88, 0));
        rdy_mode = 0;
        @(negedge clk);
        while (tx_busy) @(negedge clk);
        drain();
        verify(13'h0100, 3'd0, 8'h88, 0, 1, "R10 after stall");

        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule